// File: doc/BRIEF.md
# Funct-Coded Integer ALU

A purely combinational integer arithmetic-logic unit for a small load/store processor core. Each cycle the core presents two operands and a 6-bit operation code. That code is either the function field of a register-format instruction, or a code that the decoder maps internally for immediate add, address generation and branch compare. The unit returns a result word and a flag that is high when the result is zero.

Nine operations are supported: add, subtract, low-half multiply, signed divide, AND, OR, signed set-less-than, and left and right logical shifts. The shift count comes from a register operand.

The unit never stalls and never traps. Division by zero gives a fixed pattern, and any code that is not recognised gives zero. The data width and the divider variant (a single divide operator, or an unrolled restoring array) are parameters.

Top module: `alu_funct_core`

## Requirements
- R1: Code 6'b100000 returns a + b, modulo 2^WIDTH.
- R2: Code 6'b100010 returns a - b, modulo 2^WIDTH.
- R3: Code 6'b100100 returns the low WIDTH bits of the product a * b.
- R4: Code 6'b100101 returns the signed quotient a / b, truncated toward zero, when b is nonzero. The most negative value divided by -1 returns the most negative value.
- R5: Code 6'b100101 with b equal to 0 returns all ones, whatever the value of a.
- R6: Code 6'b101000 returns a AND b, and code 6'b101001 returns a OR b.
- R7: Code 6'b110100 returns 1 when a is less than b as signed two's-complement values, and 0 otherwise.
- R8: Code 6'b111000 shifts a left logically by b[4:0] (for WIDTH 32), and code 6'b111001 shifts a right logically by the same amount, filling with zeros. The higher bits of b are ignored.
- R9: The zero output is 1 exactly when the result is 0.
- R10: Any other code returns a result of 0, with zero high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand; holds the divisor and the shift count |
| funct | input | 6 | Operation code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is zero |

## Verification
The bench targets the sign corners of division:
- Mixed-sign operands, where a floor divider would be off by one.
- The most negative dividend over -1, where a wrapping negation could lose the result.
- Every dividend over a zero divisor, where an unguarded divider would return garbage.

Set-less-than is driven with operands of opposite sign, whose difference overflows; an unsigned compare, or a compare on the sign of the difference, gives the wrong answer there. Shifts are driven with counts of 0 and 31, and with a count whose upper bits are set; that catches a reversed direction, an arithmetic fill, or use of the whole b operand. Unused codes that sit next to valid ones check that decoding is exact.

// File: rtl/alu_funct_pkg.sv
`timescale 1ns/1ps
package alu_funct_pkg;
   localparam int FUNCT_W = 6;

   typedef enum logic [FUNCT_W-1:0] {
      FN_ADD = 6'b100000,
      FN_SUB = 6'b100010,
      FN_MUL = 6'b100100,
      FN_DIV = 6'b100101,
      FN_AND = 6'b101000,
      FN_OR  = 6'b101001,
      FN_SLT = 6'b110100,
      FN_SHL = 6'b111000,
      FN_SHR = 6'b111001
   } funct_e;

   function automatic logic funct_known(logic [FUNCT_W-1:0] f);
      case (f)
         FN_ADD, FN_SUB, FN_MUL, FN_DIV, FN_AND,
         FN_OR, FN_SLT, FN_SHL, FN_SHR: funct_known = 1'b1;
         default:                       funct_known = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             less
);
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] cin;

   assign b_eff = b ^ {WIDTH{sub}};
   assign cin   = {{(WIDTH-1){1'b0}}, sub};
   assign sum   = a + b_eff + cin;

   // Signed compare: when the signs differ the negative operand is smaller;
   // otherwise the difference cannot overflow and its sign decides.
   assign less  = (a[WIDTH-1] != b[WIDTH-1]) ? a[WIDTH-1] : sum[WIDTH-1];
endmodule

// File: rtl/alu_muldiv.sv
`timescale 1ns/1ps
module alu_muldiv #(
   parameter int WIDTH     = 32,
   parameter bit DIV_ARRAY = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] prod,
   output logic [WIDTH-1:0] quot
);
   logic             a_neg, b_neg, b_zero;
   logic [WIDTH-1:0] a_mag, b_mag, q_mag;

   assign prod   = a * b;

   assign a_neg  = a[WIDTH-1];
   assign b_neg  = b[WIDTH-1];
   assign b_zero = (b == '0);
   assign a_mag  = a_neg ? (~a + 1'b1) : a;
   assign b_mag  = b_neg ? (~b + 1'b1) : b;

   generate
      if (DIV_ARRAY) begin : g_div_array
         always_comb begin
            logic [WIDTH:0] rem;
            rem   = '0;
            q_mag = '0;
            for (int i = WIDTH - 1; i >= 0; i--) begin
               rem = {rem[WIDTH-1:0], a_mag[i]};
               if (rem >= {1'b0, b_mag}) begin
                  rem      = rem - {1'b0, b_mag};
                  q_mag[i] = 1'b1;
               end
            end
         end
      end else begin : g_div_op
         assign q_mag = b_zero ? '0 : (a_mag / b_mag);
      end
   endgenerate

   always_comb begin
      if (b_zero)             quot = '1;
      else if (a_neg ^ b_neg) quot = ~q_mag + 1'b1;
      else                    quot = q_mag;
   end
endmodule

// File: rtl/alu_logic_shift.sv
`timescale 1ns/1ps
module alu_logic_shift #(
   parameter int WIDTH = 32,
   localparam int SHW  = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             left,
   output logic [WIDTH-1:0] and_r,
   output logic [WIDTH-1:0] or_r,
   output logic [WIDTH-1:0] shifted
);
   logic [WIDTH-1:0] a_rev, s_rev;
   logic [WIDTH-1:0] stage [SHW+1];
   logic [SHW-1:0]   amt;

   assign and_r = a & b;
   assign or_r  = a | b;
   assign amt   = b[SHW-1:0];

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_rev
         assign a_rev[gi] = a[WIDTH-1-gi];
         assign s_rev[gi] = stage[SHW][WIDTH-1-gi];
      end
   endgenerate

   // One right-shift barrel serves both directions; left shifts run on the
   // bit-reversed operand and are reversed back.
   assign stage[0] = left ? a_rev : a;

   generate
      for (gi = 0; gi < SHW; gi++) begin : g_stage
         assign stage[gi+1] = amt[gi] ? (stage[gi] >> (1 << gi)) : stage[gi];
      end
   endgenerate

   assign shifted = left ? s_rev : stage[SHW];
endmodule

// File: rtl/alu_funct_core.sv
`timescale 1ns/1ps
module alu_funct_core
   import alu_funct_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter bit DIV_ARRAY = 1'b1
) (
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   input  logic [FUNCT_W-1:0] funct,
   output logic [WIDTH-1:0]   result,
   output logic               zero
);
   generate
      if (WIDTH < 8 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("alu_funct_core: WIDTH must be a power of two of at least 8");
      end
   endgenerate

   logic [WIDTH-1:0] sum, prod, quot, and_r, or_r, shifted;
   logic             less, sub_sel, left_sel;

   assign sub_sel  = (funct == FN_SUB) || (funct == FN_SLT);
   assign left_sel = (funct == FN_SHL);

   alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a(a), .b(b), .sub(sub_sel), .sum(sum), .less(less)
   );

   alu_muldiv #(.WIDTH(WIDTH), .DIV_ARRAY(DIV_ARRAY)) u_muldiv (
      .a(a), .b(b), .prod(prod), .quot(quot)
   );

   alu_logic_shift #(.WIDTH(WIDTH)) u_logic (
      .a(a), .b(b), .left(left_sel),
      .and_r(and_r), .or_r(or_r), .shifted(shifted)
   );

   always_comb begin
      case (funct)
         FN_ADD, FN_SUB: result = sum;
         FN_MUL:         result = prod;
         FN_DIV:         result = quot;
         FN_AND:         result = and_r;
         FN_OR:          result = or_r;
         FN_SLT:         result = {{(WIDTH-1){1'b0}}, less};
         FN_SHL, FN_SHR: result = shifted;
         default:        result = '0;
      endcase
   end

   assign zero = (result == '0);
endmodule

// File: rtl/alu_funct_core_chk.sv
`timescale 1ns/1ps
module alu_funct_core_chk
   import alu_funct_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0]   a,
   input logic [WIDTH-1:0]   b,
   input logic [FUNCT_W-1:0] funct,
   input logic [WIDTH-1:0]   result,
   input logic               zero
);
   always_comb begin
      // R1
      if (funct == FN_ADD)
         assert_sum_inverse_R1: assert (result - b == a) else $error("add mismatch");
      // R2
      if (funct == FN_SUB)
         assert_diff_inverse_R2: assert (result + b == a) else $error("sub mismatch");
      // R5
      if (funct == FN_DIV && b == '0)
         assert_div_zero_ones_R5: assert (&result) else $error("div by zero not all ones");
      // R6
      if (funct == FN_AND)
         assert_and_subset_R6: assert ((result & ~(a & b)) == '0 && (result | ~(a & b)) == '1)
            else $error("and mismatch");
      // R7
      if (funct == FN_SLT)
         assert_slt_bool_R7: assert (result[WIDTH-1:1] == '0) else $error("slt not boolean");
      // R10
      if (!funct_known(funct))
         assert_unknown_zero_R10: assert (result == '0) else $error("unknown code nonzero");
      // R9
      assert_zero_flag_R9: assert (zero == (result == '0)) else $error("zero flag wrong");
   end
endmodule

bind alu_funct_core alu_funct_core_chk #(.WIDTH(WIDTH)) chk_i (
   .a(a), .b(b), .funct(funct), .result(result), .zero(zero)
);

// File: tb/alu_funct_core_tb_top.sv
`timescale 1ns/1ps
module alu_funct_core_tb_top;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic [W-1:0]  a = '0, b = '0;
   logic [5:0]    funct = 6'd0;
   logic [W-1:0]  result;
   logic          zero;
   int            total = 0, bad = 0;
   bit            done = 0;

   always #5 clk = ~clk;

   alu_funct_core #(.WIDTH(W)) dut_i (
      .a(a), .b(b), .funct(funct), .result(result), .zero(zero)
   );

   function automatic logic [W-1:0] model(logic [5:0] f, logic [W-1:0] x, logic [W-1:0] y);
      logic [W-1:0] xm, ym, q;
      case (f)
         6'b100000: model = x + y;
         6'b100010: model = x - y;
         6'b100100: model = x * y;
         6'b100101: begin
            if (y == 0) model = '1;
            else begin
               xm = x[W-1] ? -x : x;
               ym = y[W-1] ? -y : y;
               q  = xm / ym;
               model = (x[W-1] != y[W-1]) ? -q : q;
            end
         end
         6'b101000: model = x & y;
         6'b101001: model = x | y;
         6'b110100: model = ($signed(x) < $signed(y)) ? 1 : 0;
         6'b111000: model = x << y[4:0];
         6'b111001: model = x >> y[4:0];
         default:   model = '0;
      endcase
   endfunction

   function automatic string tag(logic [5:0] f, logic [W-1:0] y);
      case (f)
         6'b100000: tag = "R1";
         6'b100010: tag = "R2";
         6'b100100: tag = "R3";
         6'b100101: tag = (y == 0) ? "R5" : "R4";
         6'b101000, 6'b101001: tag = "R6";
         6'b110100: tag = "R7";
         6'b111000, 6'b111001: tag = "R8";
         default:   tag = "R10";
      endcase
   endfunction

   task automatic run(logic [5:0] f, logic [W-1:0] x, logic [W-1:0] y);
      logic [W-1:0] exp;
      @(posedge clk);
      funct = f; a = x; b = y;
      exp = model(f, x, y);
      @(negedge clk);
      total++;
      if (result !== exp) begin
         bad++;
         $display("FAIL %s funct=%b a=%h b=%h actual=%h expected=%h",
                  tag(f, y), f, x, y, result, exp);
      end
      total++;
      if (zero !== (exp == 0)) begin
         bad++;
         $display("FAIL R9 funct=%b actual zero=%b expected=%b", f, zero, exp == 0);
      end
   endtask

   function automatic logic [W-1:0] pick();
      case ($urandom_range(0, 7))
         0: pick = 32'h8000_0000;
         1: pick = 32'hFFFF_FFFF;
         2: pick = 32'd0;
         3: pick = $urandom_range(0, 40);
         4: pick = -$urandom_range(1, 40);
         default: pick = $urandom;
      endcase
   endfunction

   localparam logic [5:0] CODES [9] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101,
                                        6'b101000, 6'b101001, 6'b110100, 6'b111000, 6'b111001};

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      // R10: idle code 0 at start gives 0 and zero high
      total++;
      if (result !== 0 || zero !== 1'b1) begin
         bad++;
         $display("FAIL R10 initial actual=%h/%b expected=0/1", result, zero);
      end
      run(6'b100000, 32'hFFFF_FFFF, 32'd1);          // R1 wrap to zero
      run(6'b100000, 32'd123, 32'd456);              // R1
      run(6'b100010, 32'd0, 32'd1);                  // R2
      run(6'b100010, 32'd77, 32'd77);                // R2 zero
      run(6'b100100, 32'h0001_0000, 32'h0001_0000);  // R3 low half zero
      run(6'b100100, 32'hFFFF_FFFF, 32'd3);          // R3
      run(6'b100101, -32'd7, 32'd2);                 // R4 -3
      run(6'b100101, 32'd7, -32'd2);                 // R4 -3
      run(6'b100101, -32'd7, -32'd2);                // R4 3
      run(6'b100101, 32'h8000_0000, 32'hFFFF_FFFF);  // R4 MIN/-1
      run(6'b100101, 32'd1, 32'd5);                  // R4 0
      run(6'b100101, 32'd12345, 32'd0);              // R5
      run(6'b100101, 32'h8000_0000, 32'd0);          // R5
      run(6'b100101, 32'd0, 32'd0);                  // R5
      run(6'b101000, 32'hF0F0_F0F0, 32'h0FF0_0FF0);  // R6
      run(6'b101001, 32'hF0F0_0000, 32'h000F_000F);  // R6
      run(6'b110100, 32'h8000_0000, 32'h7FFF_FFFF);  // R7 overflowing difference
      run(6'b110100, 32'h7FFF_FFFF, 32'h8000_0000);  // R7
      run(6'b110100, 32'hFFFF_FFFF, 32'd0);          // R7 -1 < 0
      run(6'b110100, 32'd5, 32'd5);                  // R7 equal
      run(6'b111000, 32'h8000_0001, 32'd31);         // R8
      run(6'b111001, 32'h8000_0001, 32'd31);         // R8 zero fill
      run(6'b111001, 32'hFFFF_FFFF, 32'hFFFF_FFE4);  // R8 upper bits ignored
      run(6'b111000, 32'h1234_5678, 32'd0);          // R8
      run(6'b100001, 32'd5, 32'd6);                  // R10 neighbour code
      run(6'b111010, 32'hFFFF_FFFF, 32'd1);          // R10
      run(6'b000000, 32'd1, 32'd1);                  // R10
      for (int i = 0; i < 3000; i++) begin
         logic [5:0] f;
         f = ($urandom_range(0, 9) == 0) ? 6'($urandom) : CODES[$urandom_range(0, 8)];
         run(f, pick(), pick());
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule